// File: doc/BRIEF.md
# CRC-16 Single-Bit Error Corrector

This block takes in a fixed-length data block followed by a 16-bit CRC. It stores the data bytes in an internal memory and updates a CRC as each byte arrives. When the second CRC byte comes in, it XORs the locally computed CRC with the received one to form a syndrome.

A zero syndrome lets the block go out unchanged. A nonzero syndrome is treated as a single flipped bit. A 16-bit LFSR is seeded with the syndrome of an error in the final data bit. Each clock it advances one step, which moves the candidate one bit earlier, until the pattern equals the syndrome or every data position has been tried. On a match, the offending bit is inverted while the block streams out. Otherwise the data goes out as received and is flagged uncorrectable. Blocks with two or more bit errors may go undetected or be miscorrected; the block makes no claim to handle them.

Both stream edges use valid/ready byte handshakes. `in_ready` is high only while a block is being collected. While the block searches for the error or streams data out, back-pressure holds the sender off. On the output side, `out_valid` stays high and `out_data`, `out_last` and `out_status` stay stable until `out_ready` takes the byte. A new block is accepted only after the last output byte has been taken.

Top module: `crc_fix_corrector`

## Requirements
- R1: A block is exactly BLOCK_BYTES data bytes, then the CRC high byte, then the CRC low byte. A byte is taken on a clock edge where in_valid and in_ready are both high, and in_ready is high only while a block is being collected.
- R2: The output carries BLOCK_BYTES bytes in arrival order, with out_last high on the final one. While out_valid is high and out_ready is low, out_data, out_last and out_status hold their values. in_ready is low from the edge that takes the last CRC byte until the last output byte is accepted.
- R3: The CRC uses polynomial 0x1021, zero initial value and no final XOR. Each data byte is shifted in most significant bit first. The syndrome is the computed CRC XOR the received CRC.
- R4: A zero syndrome gives out_status 2'b00 (clean), and the output bytes equal the received bytes.
- R5: When exactly one data bit is flipped, the output equals the original data and out_status is 2'b01 (corrected). Bit k of the block counts from 0 at the most significant bit of byte 0, so it is bit 7-(k mod 8) of byte k/8.
- R6: When exactly one bit of the CRC field is flipped, the data is output unchanged and out_status is 2'b10 (uncorrectable).
- R7: A nonzero syndrome that equals the syndrome of no single data-bit position gives the received data unchanged with out_status 2'b10. A syndrome that does equal one is corrected at that position, as in R5.
- R8: out_valid rises no later than 8*BLOCK_BYTES clock edges after the edge that takes the last CRC byte.
- R9: On the edge after the last output byte is accepted, out_valid is low and in_ready is high, so blocks can follow back to back.
- R10: While reset is held, in_ready is high and out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block is collecting input |
| in_data | input | 8 | Input byte (data, then CRC high, then CRC low) |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts output byte |
| out_data | output | 8 | Output byte, corrected when possible |
| out_last | output | 1 | Final byte of the block |
| out_status | output | 2 | 00 clean, 01 corrected, 10 uncorrectable; valid with out_valid |

## Verification
The bench builds the block with BLOCK_BYTES set to 16, which gives 128 candidate bit positions. At that size, an error in the very first data bit exercises the longest search and checks the latency bound exactly, and an error in the final bit checks the one-step match. The small block also lets the bench find the expected outcome by brute force, recomputing the CRC with each bit inverted. This covers double-bit patterns whose syndromes may or may not alias a single position. Random gaps on in_valid and random out_ready stalls test both edges under back-pressure.

// File: rtl/crc_fix_pkg.sv
package crc_fix_pkg;

  localparam logic [15:0] CRC_POLY = 16'h1021;

  typedef enum logic [1:0] {
    BLK_CLEAN = 2'b00,
    BLK_FIXED = 2'b01,
    BLK_BAD   = 2'b10
  } blk_status_e;

  typedef enum logic [1:0] {
    ST_COLLECT = 2'b00,
    ST_LOCATE  = 2'b01,
    ST_EMIT    = 2'b10
  } phase_e;

  // One LFSR step with serial input bit, MSB-first.
  function automatic logic [15:0] crc_shift(input logic [15:0] c, input logic din);
    logic fb;
    fb = c[15] ^ din;
    return {c[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
  endfunction

  function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c;
    for (int i = 7; i >= 0; i--) r = crc_shift(r, b[i]);
    return r;
  endfunction

endpackage

// File: rtl/crc_fix_crc_acc.sv
module crc_fix_crc_acc
  import crc_fix_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        en,
  input  logic [7:0]  byte_in,
  output logic [15:0] crc
);
  always_ff @(posedge clk) begin
    if (!rst_n)   crc <= 16'h0000;
    else if (clr) crc <= 16'h0000;
    else if (en)  crc <= crc_byte(crc, byte_in);
  end

  // R3: zero seed means an untouched accumulator stays zero after clearing
  a_r3_clear_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> crc == 16'h0000);
endmodule

// File: rtl/crc_fix_store.sv
module crc_fix_store #(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/crc_fix_locator.sv
module crc_fix_locator
  import crc_fix_pkg::*;
#(
  parameter int NBITS = 512,
  parameter int IW    = $clog2(NBITS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [15:0]   syn_in,
  output logic          busy,
  output logic          done,
  output logic          found,
  output logic [IW-1:0] bit_idx
);
  localparam logic [IW-1:0] LAST_STEP = IW'(NBITS - 1);

  logic [15:0]   pat;
  logic [15:0]   syn_q;
  logic [IW-1:0] step;
  logic          hit;

  assign hit     = busy && (pat == syn_q);
  assign done    = hit || (busy && step == LAST_STEP);
  assign found   = hit;
  assign bit_idx = LAST_STEP - step;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      pat   <= 16'h0000;
      syn_q <= 16'h0000;
      step  <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      pat   <= CRC_POLY;  // x^16 mod G: syndrome of an error in the final data bit
      syn_q <= syn_in;
      step  <= '0;
    end else if (busy) begin
      if (done) begin
        busy <= 1'b0;
      end else begin
        pat  <= crc_shift(pat, 1'b0);  // candidate moves one bit earlier
        step <= step + IW'(1);
      end
    end
  end

  // R8: a search is never restarted while running
  a_r8_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
  // R8: the LFSR pattern never collapses to zero during a search
  a_r8_pattern_live: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> pat != 16'h0000);
  // R8: an unfinished search advances exactly one position per cycle
  a_r8_one_step: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done && !start |=> busy && step == $past(step) + IW'(1));
endmodule

// File: rtl/crc_fix_corrector.sv
module crc_fix_corrector
  import crc_fix_pkg::*;
#(
  parameter int BLOCK_BYTES = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic       out_last,
  output logic [1:0] out_status
);
  localparam int NBITS = 8 * BLOCK_BYTES;
  localparam int AW    = $clog2(BLOCK_BYTES);
  localparam int IW    = $clog2(NBITS);
  localparam int CW    = $clog2(BLOCK_BYTES + 2);
  localparam logic [CW-1:0] CNT_HI   = CW'(BLOCK_BYTES);
  localparam logic [CW-1:0] CNT_LO   = CW'(BLOCK_BYTES + 1);
  localparam logic [AW-1:0] LAST_ADR = AW'(BLOCK_BYTES - 1);

  if (BLOCK_BYTES < 2 || BLOCK_BYTES > 256) begin : g_bad_size
    $error("BLOCK_BYTES must lie in 2..256");
  end

  phase_e        state;
  blk_status_e   status_q;
  logic [CW-1:0] rx_cnt;
  logic [7:0]    crc_hi;
  logic [AW-1:0] tx_addr;
  logic [AW-1:0] fix_addr;
  logic [7:0]    fix_mask;

  logic          in_fire, out_fire;
  logic          is_data, is_lo;
  logic [15:0]   crc_val, syn_now;
  logic [7:0]    rd_data;
  logic          loc_start, loc_busy, loc_done, loc_found;
  logic [IW-1:0] loc_idx;

  assign in_ready  = (state == ST_COLLECT);
  assign out_valid = (state == ST_EMIT);
  assign in_fire   = in_valid && in_ready;
  assign out_fire  = out_valid && out_ready;
  assign is_data   = rx_cnt < CNT_HI;
  assign is_lo     = rx_cnt == CNT_LO;
  assign syn_now   = crc_val ^ {crc_hi, in_data};
  assign loc_start = in_fire && is_lo && (syn_now != 16'h0000);

  crc_fix_crc_acc u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (in_fire && is_lo),
    .en      (in_fire && is_data),
    .byte_in (in_data),
    .crc     (crc_val)
  );

  crc_fix_store #(.DEPTH(BLOCK_BYTES), .AW(AW)) u_store (
    .clk   (clk),
    .we    (in_fire && is_data),
    .waddr (AW'(rx_cnt)),
    .wdata (in_data),
    .raddr (tx_addr),
    .rdata (rd_data)
  );

  crc_fix_locator #(.NBITS(NBITS), .IW(IW)) u_loc (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (loc_start),
    .syn_in  (syn_now),
    .busy    (loc_busy),
    .done    (loc_done),
    .found   (loc_found),
    .bit_idx (loc_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_COLLECT;
      status_q <= BLK_CLEAN;
      rx_cnt   <= '0;
      crc_hi   <= 8'h00;
      tx_addr  <= '0;
      fix_addr <= '0;
      fix_mask <= 8'h00;
    end else begin
      unique case (state)
        ST_COLLECT: if (in_fire) begin
          if (rx_cnt == CNT_HI) crc_hi <= in_data;
          if (is_lo) begin
            rx_cnt  <= '0;
            tx_addr <= '0;
            if (syn_now == 16'h0000) begin
              status_q <= BLK_CLEAN;
              fix_mask <= 8'h00;
              state    <= ST_EMIT;
            end else begin
              state <= ST_LOCATE;
            end
          end else begin
            rx_cnt <= rx_cnt + CW'(1);
          end
        end
        ST_LOCATE: if (loc_done) begin
          if (loc_found) begin
            status_q <= BLK_FIXED;
            fix_addr <= loc_idx[IW-1:3];
            fix_mask <= 8'h80 >> loc_idx[2:0];
          end else begin
            status_q <= BLK_BAD;
            fix_mask <= 8'h00;
          end
          state <= ST_EMIT;
        end
        ST_EMIT: if (out_fire) begin
          if (tx_addr == LAST_ADR) state <= ST_COLLECT;
          else tx_addr <= tx_addr + AW'(1);
        end
        default: state <= ST_COLLECT;
      endcase
    end
  end

  assign out_data   = rd_data ^ ((tx_addr == fix_addr) ? fix_mask : 8'h00);
  assign out_last   = out_valid && (tx_addr == LAST_ADR);
  assign out_status = status_q;

  // R2: a stalled output byte and its flags do not change
  a_r2_hold_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last)
                                && $stable(out_status));
  // R2: taking the last CRC byte closes the input
  a_r2_close_input: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire && is_lo |=> !in_ready);
  // R4: a clean block is streamed straight from storage
  a_r4_clean_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_status == BLK_CLEAN |-> out_data == rd_data);
  // R7: an uncorrectable block is streamed straight from storage
  a_r7_bad_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_status == BLK_BAD |-> out_data == rd_data);
  // R5: status never takes the unused code
  a_r5_status_legal: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_status != 2'b11);
  // R8: the locator is running whenever the block waits on it
  a_r8_search_live: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_LOCATE |-> loc_busy);
  // R9: the final accepted byte reopens the input
  a_r9_reopen: assert property (@(posedge clk) disable iff (!rst_n)
    out_fire && out_last |=> in_ready && !out_valid);
endmodule

// File: tb/crc_fix_corrector_bench.sv
module crc_fix_corrector_bench;
  localparam int BB = 16;
  localparam int N  = 8 * BB;

  typedef logic [7:0] blk_t [BB];

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = 8'h00;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic [7:0] out_data;
  logic       out_last;
  logic [1:0] out_status;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit summary_done = 0;

  always #4 clk = ~clk;  // 125 MHz
  always @(posedge clk) cyc <= cyc + 1;

  crc_fix_corrector #(.BLOCK_BYTES(BB)) u_crc_fix_corrector (
    .clk, .rst_n, .in_valid, .in_ready, .in_data,
    .out_valid, .out_ready, .out_data, .out_last, .out_status
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!summary_done) begin
      summary_done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    end
    $finish;
  endtask

  // Bitwise CRC from R3: poly 0x1021, zero start, MSB first, no final XOR
  function automatic logic [15:0] ref_crc(input blk_t b);
    logic [15:0] c = 16'h0000;
    for (int i = 0; i < BB; i++)
      for (int j = 7; j >= 0; j--) begin
        logic fb = c[15] ^ b[i][j];
        c = {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
      end
    return c;
  endfunction

  task automatic send_byte(input logic [7:0] b);
    while ($urandom_range(3) == 0) @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // flip positions: -1 none, 0..N-1 data bit (R5 numbering), N+m flips CRC bit 15-m
  task automatic run_block(input blk_t data, input int fa, input int fb, input string req);
    blk_t rx, expb, t;
    logic [15:0] rcrc, syn;
    int exp_st, lat, hs;
    bit hit;
    rx   = data;
    rcrc = ref_crc(data);
    foreach (rx[i]) rx[i] = data[i];
    for (int k = 0; k < 2; k++) begin
      int p = (k == 0) ? fa : fb;
      if (p >= 0 && p < N) rx[p / 8][7 - (p % 8)] ^= 1'b1;
      else if (p >= N) rcrc[15 - (p - N)] ^= 1'b1;
    end
    // Expected outcome by brute force over all single-bit flips
    expb = rx;
    syn  = ref_crc(rx) ^ rcrc;
    if (syn == 16'h0000) exp_st = 0;
    else begin
      hit = 0;
      for (int p = 0; p < N && !hit; p++) begin
        t = rx;
        t[p / 8][7 - (p % 8)] ^= 1'b1;
        if (ref_crc(t) == rcrc) begin hit = 1; expb = t; end
      end
      exp_st = hit ? 1 : 2;
    end
    for (int i = 0; i < BB; i++) begin
      check(out_valid == 1'b0, "R1", "out_valid while collecting", out_valid, 0);
      send_byte(rx[i]);
    end
    send_byte(rcrc[15:8]);
    send_byte(rcrc[7:0]);
    hs = cyc;
    check(in_ready == 1'b0, "R2", "in_ready after CRC", in_ready, 0);
    while (!out_valid && cyc - hs <= N + 4) @(negedge clk);
    lat = cyc - hs;
    check(lat <= N, "R8", "result latency", lat, N);
    for (int i = 0; i < BB;) begin
      out_ready = ($urandom_range(3) != 0);
      if (out_valid && out_ready) begin
        check(out_data == expb[i], req, "data byte", out_data, expb[i]);
        check(out_status == 2'(exp_st), req, "status", out_status, exp_st);
        check(out_last == (i == BB - 1), "R2", "out_last", out_last, i == BB - 1);
        check(in_ready == 1'b0, "R2", "in_ready while emitting", in_ready, 0);
        i++;
      end
      @(negedge clk);
    end
    out_ready = 1'b0;
    check(in_ready && !out_valid, "R9", "reopen after last", {in_ready, out_valid}, 2'b10);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    blk_t d;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(in_ready == 1'b1, "R10", "in_ready in reset", in_ready, 1);
    check(out_valid == 1'b0, "R10", "out_valid in reset", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 / R3: clean blocks
    for (int r = 0; r < 4; r++) begin
      foreach (d[i]) d[i] = 8'($urandom_range(255));
      run_block(d, -1, -1, "R4");
    end
    foreach (d[i]) d[i] = 8'h00;
    run_block(d, -1, -1, "R4");
    foreach (d[i]) d[i] = 8'hFF;
    run_block(d, -1, -1, "R4");

    // R5: single data-bit errors, first bit gives the longest search
    foreach (d[i]) d[i] = 8'($urandom_range(255));
    run_block(d, 0, -1, "R5");
    run_block(d, N - 1, -1, "R5");
    foreach (d[i]) d[i] = 8'h00;
    run_block(d, 37, -1, "R5");
    for (int r = 0; r < 6; r++) begin
      foreach (d[i]) d[i] = 8'($urandom_range(255));
      run_block(d, $urandom_range(N - 1), -1, "R5");
    end

    // R6: errors inside the CRC field
    foreach (d[i]) d[i] = 8'($urandom_range(255));
    run_block(d, N, -1, "R6");
    run_block(d, N + 15, -1, "R6");
    run_block(d, N + 7, -1, "R6");

    // R7: double errors, outcome from brute force
    for (int r = 0; r < 5; r++) begin
      int a = $urandom_range(N - 1);
      int b = (a + 1 + $urandom_range(N - 2)) % N;
      foreach (d[i]) d[i] = 8'($urandom_range(255));
      run_block(d, a, b, "R7");
    end
    foreach (d[i]) d[i] = 8'($urandom_range(255));
    run_block(d, 5, N + 3, "R7");

    finish_run();
  end
endmodule